// File: doc/BRIEF.md
# Real-Time Clock Status and Write-Guard Register

This block holds the volatile status byte of a real-time clock. It reports whether the clock runs from its backup supply. It keeps two sticky alarm flags that a status read clears, and a clock-fail flag that marks a total loss of power. It also holds a pair of enable latches. Writes to the clock/control registers are accepted only when software has set both latches in the required order.

The serial bus engine drives the block with single-cycle strobes. One strobe writes the status byte, one requests a control-register write, and one each marks the start and the end of a status read. The alarm comparators and the power monitor supply match pulses, a battery-mode level and a power-on event. The block returns the status byte and a grant. The bus engine acknowledges every control-register write, but it commits the write only when the grant is high.

Top module: `rtc_status_reg`

## Requirements
- R1: After the asynchronous reset, status bits 6..0 read 0000001: the clock-fail flag (bit 0) is 1, and both enable latches and both alarm flags are 0.
- R2: Bit 7 always equals the battery-mode input in the same cycle, and no write changes it.
- R3: Bits 4 and 3 always read 0.
- R4: A pulse on an alarm-match input sets its flag on the next clock edge (alarm 0 → bit 5, alarm 1 → bit 6), and the flag stays set until a read clears it.
- R5: On a read-end strobe, only the alarm flags that were set at the clock edge of the last read-start strobe are cleared. A flag set in the read-start cycle or later stays set. A read-end with no read-start since the previous read-end clears nothing.
- R6: A status write of 0x02 sets the write-enable latch (bit 1).
- R7: A status write of 0x06 sets the register write-enable latch (bit 2) only if bit 1 is already 1; otherwise it has no effect.
- R8: A status write of 0x00 clears both enable latches.
- R9: A status write of any other value leaves the status byte unchanged.
- R10: The grant output is high exactly when a control-register write is requested while bits 2 and 1 are both 1. An ungranted request changes no state.
- R11: A granted control-register write clears the clock-fail flag on the next clock edge.
- R12: A power-on event with both supplies lost restores the R1 state. A power-on event with only one supply lost leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (initial power-up) |
| onBattery | input | 1 | 1 while running from the backup supply |
| alarmMatch | input | 2 | Match pulses: bit 0 is alarm 0, bit 1 is alarm 1 |
| powerUp | input | 1 | Power-on event pulse |
| bothLost | input | 1 | Qualifies powerUp: both supplies had been lost |
| srWrite | input | 1 | Status write strobe |
| wrData | input | 8 | Status write data |
| ccrWrite | input | 1 | Control-register write request |
| rdStart | input | 1 | Status read start strobe |
| rdEnd | input | 1 | Status read end (last data bit) strobe |
| statusByte | output | 8 | Status byte |
| ccrGrant | output | 1 | Control-register write accepted |

## Verification
The enable sequence is tried in the correct order, in the wrong order, with stray bit patterns and with the clear pattern. This separates the gating of bit 2 on bit 1 from simple pattern matching. Alarm reads are tried in three ways: with flags set before the read, with a match in the same cycle as the read start, and with a read end that has no matching start. Each of these separates the snapshot-based clear from a plain clear-on-read. Power-on events are tried with and without total loss, which shows whether clock-fail is set only by a full outage. A long random phase then mixes all strobes and compares the block with a behavioural model on every clock.

// File: rtl/rtc_status_pkg.sv
package rtc_status_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_ALARMS = 2;
  localparam logic [DATA_W-1:0] WEL_PATTERN  = 8'h02;
  localparam logic [DATA_W-1:0] RWEL_PATTERN = 8'h06;
  localparam logic [DATA_W-1:0] CLEAR_PATTERN = 8'h00;

  typedef struct packed {
    logic setWel;
    logic setRwel;
    logic clearLatches;
    logic takeSnap;
    logic dropAlarms;
    logic powerInit;
    logic clearFail;
  } statusStrobes_t;
endpackage

// File: rtl/rtc_status_ctrl.sv
module rtc_status_ctrl
  import rtc_status_pkg::*;
(
  input  logic              srWrite,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ccrWrite,
  input  logic              rdStart,
  input  logic              rdEnd,
  input  logic              powerUp,
  input  logic              bothLost,
  input  logic              welQ,
  input  logic              rwelQ,
  output statusStrobes_t    strobes,
  output logic              ccrGrant
);
  logic grantInt;

  always_comb begin
    grantInt = ccrWrite && welQ && rwelQ;
    strobes.setWel       = srWrite && (wrData == WEL_PATTERN);
    strobes.setRwel      = srWrite && (wrData == RWEL_PATTERN) && welQ;
    strobes.clearLatches = srWrite && (wrData == CLEAR_PATTERN);
    strobes.takeSnap     = rdStart;
    strobes.dropAlarms   = rdEnd;
    strobes.powerInit    = powerUp && bothLost;
    strobes.clearFail    = grantInt;
  end

  assign ccrGrant = grantInt;
endmodule

// File: rtl/rtc_status_dp.sv
module rtc_status_dp
  import rtc_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  statusStrobes_t        strobes,
  input  logic [NUM_ALARMS-1:0] alarmMatch,
  output logic                  welQ,
  output logic                  rwelQ,
  output logic [NUM_ALARMS-1:0] alarmQ,
  output logic                  failQ
);
  logic [NUM_ALARMS-1:0] snapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      rwelQ <= 1'b0;
      failQ <= 1'b1;
    end else if (strobes.powerInit) begin
      welQ  <= 1'b0;
      rwelQ <= 1'b0;
      failQ <= 1'b1;
    end else begin
      if (strobes.clearLatches) begin
        welQ  <= 1'b0;
        rwelQ <= 1'b0;
      end else begin
        if (strobes.setWel)  welQ  <= 1'b1;
        if (strobes.setRwel) rwelQ <= 1'b1;
      end
      if (strobes.clearFail) failQ <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        alarmQ[i] <= 1'b0;
        snapQ[i]  <= 1'b0;
      end else if (strobes.powerInit) begin
        alarmQ[i] <= 1'b0;
        snapQ[i]  <= 1'b0;
      end else begin
        if (alarmMatch[i])
          alarmQ[i] <= 1'b1;
        else if (strobes.dropAlarms && snapQ[i])
          alarmQ[i] <= 1'b0;
        if (strobes.takeSnap)
          snapQ[i] <= alarmQ[i];
        else if (strobes.dropAlarms)
          snapQ[i] <= 1'b0;
      end
    end

    // R4: a match pulse leaves its flag set
    a_r4_match_sets: assert property (@(posedge clk) disable iff (!rstN)
      alarmMatch[i] && !strobes.powerInit |=> alarmQ[i]);

    // R5: a flag absent from the snapshot survives read end
    a_r5_fresh_survives: assert property (@(posedge clk) disable iff (!rstN)
      strobes.dropAlarms && !snapQ[i] && alarmQ[i] && !strobes.powerInit |=> alarmQ[i]);
  end

  // R7: register latch never set without the write-enable latch
  a_r7_rwel_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    rwelQ |-> welQ);

  // R11: clock-fail drops only after a granted control write
  a_r11_fail_drop_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(failQ) |-> $past(strobes.clearFail));
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  onBattery,
  input  logic [NUM_ALARMS-1:0] alarmMatch,
  input  logic                  powerUp,
  input  logic                  bothLost,
  input  logic                  srWrite,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  ccrWrite,
  input  logic                  rdStart,
  input  logic                  rdEnd,
  output logic [DATA_W-1:0]     statusByte,
  output logic                  ccrGrant
);
  statusStrobes_t        strobes;
  logic                  welQ;
  logic                  rwelQ;
  logic                  failQ;
  logic [NUM_ALARMS-1:0] alarmQ;

  rtc_status_ctrl u_ctrl (
    .srWrite (srWrite),
    .wrData  (wrData),
    .ccrWrite(ccrWrite),
    .rdStart (rdStart),
    .rdEnd   (rdEnd),
    .powerUp (powerUp),
    .bothLost(bothLost),
    .welQ    (welQ),
    .rwelQ   (rwelQ),
    .strobes (strobes),
    .ccrGrant(ccrGrant)
  );

  rtc_status_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .alarmMatch(alarmMatch),
    .welQ      (welQ),
    .rwelQ     (rwelQ),
    .alarmQ    (alarmQ),
    .failQ     (failQ)
  );

  assign statusByte = {onBattery, alarmQ, 2'b00, rwelQ, welQ, failQ};

  // R3: spare bits stay zero
  a_r3_spare_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[4:3] == 2'b00);

  // R12: a power-on event without total loss keeps clock-fail
  a_r12_partial_loss: assert property (@(posedge clk) disable iff (!rstN)
    powerUp && !bothLost && !ccrWrite |=> $stable(statusByte[0]));

  // R10: a granted write always sees both latches set
  a_r10_grant_latched: assert property (@(posedge clk) disable iff (!rstN)
    ccrGrant |-> ccrWrite && statusByte[2] && statusByte[1]);
endmodule

// File: tb/test_rtc_status_reg.sv
module test_rtc_status_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       onBattery = 1'b0;
  logic [1:0] alarmMatch = 2'b00;
  logic       powerUp = 1'b0;
  logic       bothLost = 1'b0;
  logic       srWrite = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       ccrWrite = 1'b0;
  logic       rdStart = 1'b0;
  logic       rdEnd = 1'b0;
  logic [7:0] statusByte;
  logic       ccrGrant;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // reference model state
  bit mWel, mRwel, mFail;
  bit [1:0] mAl, mSnap;

  always #4 clk = ~clk;

  rtc_status_reg i_rtc_status_reg (
    .clk(clk), .rstN(rstN), .onBattery(onBattery), .alarmMatch(alarmMatch),
    .powerUp(powerUp), .bothLost(bothLost), .srWrite(srWrite), .wrData(wrData),
    .ccrWrite(ccrWrite), .rdStart(rdStart), .rdEnd(rdEnd),
    .statusByte(statusByte), .ccrGrant(ccrGrant)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWel = 0; mRwel = 0; mFail = 1; mAl = 0; mSnap = 0;
    end else if (powerUp && bothLost) begin
      mWel = 0; mRwel = 0; mFail = 1; mAl = 0; mSnap = 0;
    end else begin
      bit [1:0] oldAl;
      bit oldWel, oldRwel;
      oldAl = mAl; oldWel = mWel; oldRwel = mRwel;
      if (ccrWrite && oldWel && oldRwel) mFail = 0;
      if (srWrite) begin
        if (wrData == 8'h02) mWel = 1;
        else if (wrData == 8'h06 && oldWel) mRwel = 1;
        else if (wrData == 8'h00) begin mWel = 0; mRwel = 0; end
      end
      if (rdEnd) mAl = oldAl & ~mSnap;
      mAl = mAl | alarmMatch;
      if (rdStart) mSnap = oldAl;
      else if (rdEnd) mSnap = 0;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [7:0] expB;
      expB = {onBattery, mAl, 2'b00, mRwel, mWel, mFail};
      check("R2 battery bit", {7'd0, statusByte[7]}, {7'd0, expB[7]});
      check("R4/R5 alarm bits", {6'd0, statusByte[6:5]}, {6'd0, expB[6:5]});
      check("R3 spare bits", {6'd0, statusByte[4:3]}, 8'd0);
      check("R6/R7/R8 latch bits", {6'd0, statusByte[2:1]}, {6'd0, expB[2:1]});
      check("R11 clock-fail bit", {7'd0, statusByte[0]}, {7'd0, expB[0]});
      check("R10 grant", {7'd0, ccrGrant}, {7'd0, ccrWrite & mWel & mRwel});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    alarmMatch = 0; powerUp = 0; bothLost = 0; srWrite = 0;
    ccrWrite = 0; rdStart = 0; rdEnd = 0;
  endtask

  task automatic srWr(logic [7:0] d);
    srWrite = 1; wrData = d; tick(); idle();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    check("R1 reset state", {1'b0, statusByte[6:0]}, 8'h01);
    onBattery = 1; #1;
    check("R2 bit7 follows battery", {7'd0, statusByte[7]}, 8'd1);
    srWr(8'hFF);
    check("R9 stray write", statusByte, 8'h81);
    onBattery = 0;
    alarmMatch = 2'b01; tick(); idle();
    check("R4 alarm0 bit5", statusByte, 8'h21);
    alarmMatch = 2'b10; tick(); idle();
    check("R4 alarm1 bit6", statusByte, 8'h61);
    rdStart = 1; tick(); idle();
    rdEnd = 1; tick(); idle();
    check("R5 read clears both", statusByte, 8'h01);
    alarmMatch = 2'b01; tick(); idle();
    rdStart = 1; alarmMatch = 2'b10; tick(); idle();
    rdEnd = 1; tick(); idle();
    check("R5 fresh alarm survives", statusByte, 8'h41);
    rdEnd = 1; tick(); idle();
    check("R5 end without start", statusByte, 8'h41);
    rdStart = 1; tick(); idle();
    rdEnd = 1; tick(); idle();
    check("R5 second read clears", statusByte, 8'h01);
    srWr(8'h06);
    check("R7 out-of-order ignored", statusByte, 8'h01);
    ccrWrite = 1; #1;
    check("R10 no grant locked", {7'd0, ccrGrant}, 8'd0);
    tick(); idle();
    check("R10 ungranted no change", statusByte, 8'h01);
    srWr(8'h02);
    check("R6 wel set", statusByte, 8'h03);
    srWr(8'h03);
    check("R9 other pattern", statusByte, 8'h03);
    srWr(8'h06);
    check("R7 rwel set", statusByte, 8'h07);
    ccrWrite = 1; #1;
    check("R10 grant", {7'd0, ccrGrant}, 8'd1);
    tick(); idle();
    check("R11 fail cleared", statusByte, 8'h06);
    srWr(8'h00);
    check("R8 latches cleared", statusByte, 8'h00);
    alarmMatch = 2'b01; tick(); idle();
    powerUp = 1; bothLost = 0; tick(); idle();
    check("R12 partial loss keeps", statusByte, 8'h20);
    srWr(8'h02); srWr(8'h06);
    powerUp = 1; bothLost = 1; tick(); idle();
    check("R12 total loss restores", statusByte, 8'h01);

    for (int n = 0; n < 4000; n++) begin
      int sel;
      onBattery  = $urandom_range(0, 1);
      alarmMatch = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      rdStart    = ($urandom_range(0, 5) == 0);
      rdEnd      = ($urandom_range(0, 5) == 0);
      ccrWrite   = ($urandom_range(0, 4) == 0);
      powerUp    = ($urandom_range(0, 60) == 0);
      bothLost   = $urandom_range(0, 1);
      srWrite    = ($urandom_range(0, 3) == 0);
      sel = $urandom_range(0, 4);
      wrData = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h02 : (sel == 2) ? 8'h06
             : 8'($urandom_range(0, 255));
      tick();
    end
    idle();
    tick();
    @(negedge clk); #1;
    finishRun();
  end
endmodule